// File: doc/BRIEF.md
# Moore-Type Bit-Serial Adder

This block adds two unsigned operands of WIDTH bits using a single full adder, handling one bit position per clock cycle and starting from the least significant bit. Holding the combined reset/load pin high for a cycle captures both operands into internal right-shifting registers. It also clears the result register, returns the adder state to "no carry, sum bit 0" and presets a cycle counter. Once the pin drops, the operands shift toward bit 0, and their bit 0 feeds the adder each cycle.

The adder keeps both the running carry and the freshly produced sum bit in two flip-flops. The four possible states are the combinations of carry and sum bit. The serial output is the stored sum bit, so it depends only on the state and appears one cycle after the operand bits that produced it. Because of that one-cycle lag, the result shift register runs for WIDTH+1 cycles; the first bit it captures is the meaningless reset value, and that bit is pushed out of the bottom by the last shift. After the counter reaches zero, everything freezes. The parallel output then holds the sum modulo 2^WIDTH, and the final carry is dropped.

The block has no handshake. A caller raises the load pin with the operands present, lowers it, and reads the result WIDTH+1 cycles later. Raising the load pin again at any time aborts the current addition and starts a new one.

Top module: `bitser_add`

## Requirements
- R1: A cycle with rst_load high clears sum to zero at that clock edge, with no dependence on any earlier addition.
- R2: After the load edge, with rst_load held low, sum equals (opa + opb) mod 2^WIDTH once WIDTH+1 further rising edges have occurred.
- R3: The carry out of bit WIDTH-1 is discarded; for example, with WIDTH=8, 0xFF + 0x01 gives 0x00 and 0x80 + 0x80 gives 0x00.
- R4: Once the WIDTH+1 cycles have elapsed, sum keeps its value for as long as rst_load stays low, whatever opa and opb do.
- R5: opa and opb are sampled only on edges where rst_load is high; changes to them while rst_load is low do not affect the result.
- R6: Raising rst_load in the middle of an addition abandons it; the result of the new operands appears WIDTH+1 edges after that new load.
- R7: A carry propagates through every bit position; for example, with WIDTH=8, 0x7F + 0x01 gives 0x80 and 0xFF + 0xFF gives 0xFE.
- R8: The result is produced least significant bit first through a registered sum bit. After the m-th edge following the load (2 <= m <= WIDTH+1), sum[WIDTH-1] holds bit m-2 of the true sum.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_load | input | 1 | Synchronous reset and operand load, active high |
| opa | input | WIDTH | First operand, captured while rst_load is high |
| opb | input | WIDTH | Second operand, captured while rst_load is high |
| sum | output | WIDTH | Parallel result register |

## Verification
Every result is timed from the edge that captures the operands. The clear of sum shows right after that edge. Bit k of the sum first appears in sum[WIDTH-1] after edge k+2 following the load, and the complete result is in place after edge WIDTH+1. The bench drives inputs and samples outputs on the falling edge. It counts rising edges from the load to know which value is due at each sample: it checks the top bit after each edge in turn, compares the full result at edge WIDTH+1, and then rechecks that result over several more edges while the operand pins are scrambled.

// File: rtl/sadd_pkg.sv
package sadd_pkg;
  // state bit 1 = carry, bit 0 = stored sum bit
  typedef enum logic [1:0] {
    ST_G0 = 2'b00,
    ST_G1 = 2'b01,
    ST_H0 = 2'b10,
    ST_H1 = 2'b11
  } sadd_state_e;

  function automatic sadd_state_e full_add(input logic a, input logic b, input logic cin);
    logic [1:0] r;
    r = {(a & b) | (a & cin) | (b & cin), a ^ b ^ cin};
    return sadd_state_e'(r);
  endfunction
endpackage

// File: rtl/sadd_shreg.sv
module sadd_shreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         load,
  input  logic         en,
  input  logic [W-1:0] din,
  input  logic         sin,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (load)
      q <= din;
    else if (en)
      q <= {sin, q[W-1:1]};
  end

  // R5: contents frozen when neither loading nor shifting
  a_r5_shreg_hold: assert property (@(posedge clk) disable iff (load)
    !en |=> $stable(q));
endmodule

// File: rtl/sadd_cell.sv
module sadd_cell
  import sadd_pkg::*;
(
  input  logic clk,
  input  logic clr,
  input  logic en,
  input  logic a,
  input  logic b,
  output logic s
);
  sadd_state_e state;
  sadd_state_e nxt;

  always_comb begin
    nxt = full_add(a, b, state[1]);
  end

  always_ff @(posedge clk) begin
    if (clr)
      state <= ST_G0;
    else if (en)
      state <= nxt;
  end

  assign s = state[0];

  // R7: both operand bits set always leaves a carry
  a_r7_carry_set: assert property (@(posedge clk) disable iff (clr)
    (en && a && b) |=> state[1]);
  // R7: both operand bits clear always kills the carry
  a_r7_carry_kill: assert property (@(posedge clk) disable iff (clr)
    (en && !a && !b) |=> !state[1]);
  // R4: state frozen while idle
  a_r4_cell_idle: assert property (@(posedge clk) disable iff (clr)
    !en |=> $stable(state));
endmodule

// File: rtl/sadd_cnt.sv
module sadd_cnt #(
  parameter int STEPS = 9
) (
  input  logic clk,
  input  logic preset,
  output logic run
);
  localparam int CW = $clog2(STEPS + 1);
  localparam logic [CW-1:0] START = CW'(STEPS);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (preset)
      cnt <= START;
    else if (run)
      cnt <= cnt - 1'b1;
  end

  assign run = (cnt != '0);

  // R2: once exhausted, the count stays at zero until the next load
  a_r2_cnt_stop: assert property (@(posedge clk) disable iff (preset)
    (cnt == '0) |=> (cnt == '0));
endmodule

// File: rtl/bitser_add.sv
module bitser_add #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_load,
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  output logic [WIDTH-1:0] sum
);
  // one extra cycle because the sum bit is registered
  localparam int STEPS = WIDTH + 1;

  logic             run;
  logic             sbit;
  logic [WIDTH-1:0] qa;
  logic [WIDTH-1:0] qb;

  sadd_cnt #(.STEPS(STEPS)) u_cnt (
    .clk    (clk),
    .preset (rst_load),
    .run    (run)
  );

  sadd_shreg #(.W(WIDTH)) u_sh_a (
    .clk (clk), .load (rst_load), .en (run),
    .din (opa), .sin (1'b0), .q (qa)
  );

  sadd_shreg #(.W(WIDTH)) u_sh_b (
    .clk (clk), .load (rst_load), .en (run),
    .din (opb), .sin (1'b0), .q (qb)
  );

  sadd_cell u_cell (
    .clk (clk), .clr (rst_load), .en (run),
    .a   (qa[0]), .b (qb[0]), .s (sbit)
  );

  sadd_shreg #(.W(WIDTH)) u_sh_s (
    .clk (clk), .load (rst_load), .en (run),
    .din ('0), .sin (sbit), .q (sum)
  );

  // R4: finished result does not move
  a_r4_result_hold: assert property (@(posedge clk) disable iff (rst_load)
    !run |=> $stable(sum));
endmodule

// File: tb/bitser_add_test.sv
module bitser_add_test;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_load = 1'b1;
  logic [N-1:0] opa = '0;
  logic [N-1:0] opb = '0;
  logic [N-1:0] sum;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  bitser_add #(.WIDTH(N)) uut (
    .clk (clk), .rst_load (rst_load), .opa (opa), .opb (opb), .sum (sum)
  );

  function automatic logic [N-1:0] ref_sum(input logic [N-1:0] a, input logic [N-1:0] b);
    logic [N:0] t;
    t = {1'b0, a} + {1'b0, b};
    return t[N-1:0];
  endfunction

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // load at a falling edge, return at the falling edge after the load edge
  task automatic do_load(input logic [N-1:0] a, input logic [N-1:0] b);
    @(negedge clk);
    rst_load = 1'b1; opa = a; opb = b;
    @(posedge clk);
    @(negedge clk);
    rst_load = 1'b0;
  endtask

  task automatic t_clear_and_add(input string req, input logic [N-1:0] a, input logic [N-1:0] b);
    do_load(a, b);
    chk("R1", sum, '0);
    repeat (N + 1) @(negedge clk);
    chk(req, sum, ref_sum(a, b));
  endtask

  task automatic t_serial_order(input logic [N-1:0] a, input logic [N-1:0] b);
    logic [N-1:0] e;
    e = ref_sum(a, b);
    do_load(a, b);
    for (int m = 1; m <= N + 1; m++) begin
      @(negedge clk);
      if (m >= 2) chk("R8", {{(N-1){1'b0}}, sum[N-1]}, {{(N-1){1'b0}}, e[m-2]});
    end
    chk("R2", sum, e);
  endtask

  task automatic t_ignore_inputs(input logic [N-1:0] a, input logic [N-1:0] b);
    do_load(a, b);
    for (int m = 1; m <= N + 1; m++) begin
      opa = N'(m * 37 + 5); opb = N'(m * 91 + 3);
      @(negedge clk);
    end
    chk("R5", sum, ref_sum(a, b));
  endtask

  task automatic t_hold(input logic [N-1:0] a, input logic [N-1:0] b);
    do_load(a, b);
    repeat (N + 1) @(negedge clk);
    for (int k = 0; k < 6; k++) begin
      opa = N'(k * 53 + 11); opb = ~opa;
      @(negedge clk);
      chk("R4", sum, ref_sum(a, b));
    end
  endtask

  task automatic t_restart(input logic [N-1:0] a, input logic [N-1:0] b);
    do_load(8'h5A, 8'hC3);
    repeat (3) @(negedge clk);
    do_load(a, b);
    chk("R6 clear", sum, '0);
    repeat (N + 1) @(negedge clk);
    chk("R6", sum, ref_sum(a, b));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset", sum, '0);
    t_clear_and_add("R2", 8'h12, 8'h34);
    t_clear_and_add("R2", 8'h00, 8'h00);
    t_clear_and_add("R2", 8'hA5, 8'h5A);
    t_clear_and_add("R3", 8'hFF, 8'h01);
    t_clear_and_add("R3", 8'h80, 8'h80);
    t_clear_and_add("R7", 8'h7F, 8'h01);
    t_clear_and_add("R7", 8'hFF, 8'hFF);
    t_serial_order(8'h6B, 8'h2D);
    t_serial_order(8'hF0, 8'h1F);
    t_ignore_inputs(8'h3C, 8'h99);
    t_hold(8'hC8, 8'h4E);
    t_restart(8'h01, 8'hFE);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule